// File: doc/BRIEF.md
# Temperature-Aware All-Bank Refresh Scheduler

This block paces all-bank refresh operations for a DRAM device so that a fixed number of refreshes, `REF_COUNT`, lands inside every retention window. The window is `RETENTION_US` microseconds when the device is cool. When the `hotTemp` input is high the window is half as long. An interval timer counts clock cycles and adds one owed refresh at each interval boundary. The average interval in cycles is computed from the clock-frequency parameter.

Owed refreshes go to the command arbiter as a request. The arbiter may defer them, up to `POSTPONE_MAX` of them. When the owed count reaches that limit, the block flags the request as urgent. Once the arbiter grants a refresh, the block holds a device-busy flag for exactly `TRFC_CYC` cycles. When the busy window closes, a row-group counter advances so that the scheduler can report which slice of the device was last refreshed. Self-refresh, per-bank refresh and command encoding are handled elsewhere.

Top module: `refresh_sched`

## Requirements
- R1: During and straight after reset, `refReq`, `refUrgent` and `devBusy` are 0, and `owedCount` and `rowGroup` are 0.
- R2: With `hotTemp` low, one refresh becomes owed every NORM cycles, where NORM = floor(CLK_MHZ*RETENTION_US/REF_COUNT). The first one is owed on the NORM-th rising edge after reset is released.
- R3: With `hotTemp` high, the interval is HOT = floor(CLK_MHZ*RETENTION_US/(2*REF_COUNT)) cycles.
- R4: `hotTemp` is sampled only at an interval boundary and selects the length of the interval that starts there. A change between boundaries does not alter the interval already running. The first interval after reset always has the NORM length.
- R5: `refReq` is 1 exactly when `owedCount` is nonzero and `devBusy` is 0. A `refGrant` seen while `refReq` is 0 has no effect.
- R6: A grant is accepted at a rising edge where `refReq` and `refGrant` are both 1. After that edge, `devBusy` is 1 for exactly `TRFC_CYC` cycles, and `owedCount` drops by one at the accepting edge.
- R7: `owedCount` never exceeds `POSTPONE_MAX`. A boundary that arrives at the limit without an accepted grant adds nothing. `refUrgent` is 1 exactly when `owedCount` equals `POSTPONE_MAX`.
- R8: `rowGroup` increases by one on the edge where each busy window ends and nowhere else. It wraps to 0 after REF_COUNT-1 (REF_COUNT is a power of two).
- R9: When every request is granted at once, REF_COUNT grants are accepted within one cool retention window, and none while `devBusy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hotTemp | input | 1 | High-temperature flag, halves the retention window |
| refGrant | input | 1 | Arbiter grant for the pending refresh |
| refReq | output | 1 | A refresh is owed and the device is free |
| refUrgent | output | 1 | Owed count is at the postponement limit |
| devBusy | output | 1 | Device is inside the refresh recovery window |
| owedCount | output | $clog2(POSTPONE_MAX+1) | Number of refreshes owed |
| rowGroup | output | $clog2(REF_COUNT) | Row-group index of completed refreshes |

## Verification
The bench targets the exact edge of each interval boundary. An off-by-one timer would add an owed refresh one cycle early or late. It also drops `hotTemp` in the middle of an interval. A design that applied the flag at once would shorten or lengthen an interval that was already running. It drives grants while the device is busy and while nothing is owed, so a leaky accept would change the owed count or restart the busy window. It also lets the owed count reach the limit with one more boundary to come. A design without saturation would wrap the count, and a design with the wrong `refUrgent` decode would miss the limit.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } refState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic reloadHot;   // restart interval timer with the hot length
    logic reloadNorm;  // restart interval timer with the cool length
    logic countIv;     // decrement interval timer
    logic loadTrfc;    // start recovery window
    logic countTrfc;   // decrement recovery counter
    logic incOwed;     // one more refresh owed
    logic decOwed;     // one refresh granted
    logic incRow;      // a refresh completed
  } refStrobe_t;

endpackage

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int IV_NORM   = 6250,
  parameter int IV_HOT    = 3125,
  parameter int TRFC_CYC  = 280,
  parameter int MAX_OWED  = 8,
  parameter int REF_COUNT = 8192
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  refStrobe_t                    strobe,
  output logic                          ivZero,
  output logic                          trfcZero,
  output logic                          owedZero,
  output logic                          owedFull,
  output logic [$clog2(MAX_OWED+1)-1:0] owedCount,
  output logic [$clog2(REF_COUNT)-1:0]  rowGroup
);

  localparam int IVW  = $clog2(IV_NORM);
  localparam int TW   = $clog2(TRFC_CYC + 1);
  localparam int OW   = $clog2(MAX_OWED + 1);
  localparam int ROWW = $clog2(REF_COUNT);

  logic [IVW-1:0] ivCnt;
  logic [TW-1:0]  trfcCnt;

  // interval timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivCnt <= IVW'(IV_NORM - 1);
    end else if (strobe.reloadHot) begin
      ivCnt <= IVW'(IV_HOT - 1);
    end else if (strobe.reloadNorm) begin
      ivCnt <= IVW'(IV_NORM - 1);
    end else if (strobe.countIv) begin
      ivCnt <= ivCnt - IVW'(1);
    end
  end

  // recovery window counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trfcCnt <= '0;
    end else if (strobe.loadTrfc) begin
      trfcCnt <= TW'(TRFC_CYC - 1);
    end else if (strobe.countTrfc && trfcCnt != '0) begin
      trfcCnt <= trfcCnt - TW'(1);
    end
  end

  // owed refresh counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      owedCount <= '0;
    end else begin
      unique case ({strobe.incOwed, strobe.decOwed})
        2'b10:   owedCount <= owedCount + OW'(1);
        2'b01:   owedCount <= owedCount - OW'(1);
        default: owedCount <= owedCount;
      endcase
    end
  end

  // row-group counter, wraps naturally at a power of two
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowGroup <= '0;
    end else if (strobe.incRow) begin
      rowGroup <= rowGroup + ROWW'(1);
    end
  end

  assign ivZero   = (ivCnt == '0);
  assign trfcZero = (trfcCnt == '0);
  assign owedZero = (owedCount == '0);
  assign owedFull = (owedCount == OW'(MAX_OWED));

endmodule

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hotTemp,
  input  logic       refGrant,
  input  logic       ivZero,
  input  logic       trfcZero,
  input  logic       owedZero,
  input  logic       owedFull,
  output refStrobe_t strobe,
  output logic       refReq,
  output logic       devBusy
);

  refState_t state, stateNext;
  logic      accept;

  assign refReq  = (state == ST_IDLE) && !owedZero;
  assign devBusy = (state == ST_BUSY);
  assign accept  = refReq && refGrant;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept)   stateNext = ST_BUSY;
      ST_BUSY: if (trfcZero) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe            = '0;
    strobe.reloadHot  = ivZero && hotTemp;
    strobe.reloadNorm = ivZero && !hotTemp;
    strobe.countIv    = !ivZero;
    strobe.loadTrfc   = accept;
    strobe.countTrfc  = devBusy;
    strobe.decOwed    = accept;
    strobe.incOwed    = ivZero && (!owedFull || accept);
    strobe.incRow     = devBusy && trfcZero;
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int CLK_MHZ      = 800,
  parameter int RETENTION_US = 64000,
  parameter int REF_COUNT    = 8192,
  parameter int TRFC_CYC     = 280,
  parameter int POSTPONE_MAX = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              hotTemp,
  input  logic                              refGrant,
  output logic                              refReq,
  output logic                              refUrgent,
  output logic                              devBusy,
  output logic [$clog2(POSTPONE_MAX+1)-1:0] owedCount,
  output logic [$clog2(REF_COUNT)-1:0]      rowGroup
);

  localparam int IV_NORM = (CLK_MHZ * RETENTION_US) / REF_COUNT;
  localparam int IV_HOT  = (CLK_MHZ * RETENTION_US) / (2 * REF_COUNT);

  refStrobe_t strobe;
  logic ivZero, trfcZero, owedZero, owedFull;

  refresh_sched_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .hotTemp  (hotTemp),
    .refGrant (refGrant),
    .ivZero   (ivZero),
    .trfcZero (trfcZero),
    .owedZero (owedZero),
    .owedFull (owedFull),
    .strobe   (strobe),
    .refReq   (refReq),
    .devBusy  (devBusy)
  );

  refresh_sched_dp #(
    .IV_NORM   (IV_NORM),
    .IV_HOT    (IV_HOT),
    .TRFC_CYC  (TRFC_CYC),
    .MAX_OWED  (POSTPONE_MAX),
    .REF_COUNT (REF_COUNT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ivZero    (ivZero),
    .trfcZero  (trfcZero),
    .owedZero  (owedZero),
    .owedFull  (owedFull),
    .owedCount (owedCount),
    .rowGroup  (rowGroup)
  );

  assign refUrgent = owedFull;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int TRFC_CYC  = 280,
  parameter int MAX_OWED  = 8,
  parameter int REF_COUNT = 8192
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          refGrant,
  input logic                          refReq,
  input logic                          refUrgent,
  input logic                          devBusy,
  input logic [$clog2(MAX_OWED+1)-1:0] owedCount,
  input logic [$clog2(REF_COUNT)-1:0]  rowGroup
);

  localparam int ROWW = $clog2(REF_COUNT);
  localparam int TW   = $clog2(TRFC_CYC + 2);

  logic [TW-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)        busyRun <= '0;
    else if (devBusy) busyRun <= busyRun + TW'(1);
    else              busyRun <= '0;
  end

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    devBusy |-> !refReq); // R6

  AST_ACCEPT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=> (devBusy && owedCount <= $past(owedCount))); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devBusy) |-> (busyRun == TW'(TRFC_CYC))); // R6

  AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (int'(owedCount) <= MAX_OWED)); // R7

  AST_URGENT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> (int'(owedCount) == MAX_OWED)); // R7

  AST_ROW_ONLY_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    (rowGroup != $past(rowGroup)) |-> $fell(devBusy)); // R8

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devBusy) |-> (rowGroup == $past(rowGroup) + ROWW'(1))); // R8

  AST_REQ_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> (owedCount != '0)); // R5

endmodule

bind refresh_sched refresh_sched_chk #(
  .TRFC_CYC  (TRFC_CYC),
  .MAX_OWED  (POSTPONE_MAX),
  .REF_COUNT (REF_COUNT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .refGrant  (refGrant),
  .refReq    (refReq),
  .refUrgent (refUrgent),
  .devBusy   (devBusy),
  .owedCount (owedCount),
  .rowGroup  (rowGroup)
);

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;

  localparam int CLK_MHZ      = 250;
  localparam int RETENTION_US = 1;
  localparam int REF_COUNT    = 8;
  localparam int TRFC_CYC     = 5;
  localparam int POSTPONE_MAX = 3;
  localparam int NORM = (CLK_MHZ * RETENTION_US) / REF_COUNT;       // 31
  localparam int HOT  = (CLK_MHZ * RETENTION_US) / (2 * REF_COUNT); // 15
  localparam int WINDOW = CLK_MHZ * RETENTION_US;                   // 250

  logic clk = 1'b0;
  logic rstN, hotTemp, refGrant;
  logic refReq, refUrgent, devBusy;
  logic [$clog2(POSTPONE_MAX+1)-1:0] owedCount;
  logic [$clog2(REF_COUNT)-1:0]      rowGroup;

  int total = 0;
  int bad   = 0;
  int kNow  = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  refresh_sched #(
    .CLK_MHZ      (CLK_MHZ),
    .RETENTION_US (RETENTION_US),
    .REF_COUNT    (REF_COUNT),
    .TRFC_CYC     (TRFC_CYC),
    .POSTPONE_MAX (POSTPONE_MAX)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .hotTemp   (hotTemp),
    .refGrant  (refGrant),
    .refReq    (refReq),
    .refUrgent (refUrgent),
    .devBusy   (devBusy),
    .owedCount (owedCount),
    .rowGroup  (rowGroup)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at k=%0d: actual=%0d expected=%0d", tag, kNow, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; hotTemp = 1'b0; refGrant = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    kNow = 0;
  endtask

  task automatic stepTo(int k);
    while (kNow < k) begin
      @(negedge clk);
      kNow++;
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; hotTemp = 1'b1; refGrant = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 refReq", refReq, 0);
    chk("R1 refUrgent", refUrgent, 0);
    chk("R1 devBusy", devBusy, 0);
    chk("R1 owedCount", owedCount, 0);
    chk("R1 rowGroup", rowGroup, 0);
  endtask

  task automatic t_normal_and_grant();
    doReset();
    stepTo(NORM - 1);
    chk("R2 owed before first boundary", owedCount, 0);
    stepTo(NORM);
    chk("R2 owed at first boundary", owedCount, 1);
    chk("R5 request raised", refReq, 1);
    stepTo(2 * NORM - 1);
    chk("R2 owed before second boundary", owedCount, 1);
    stepTo(2 * NORM);
    chk("R2 owed at second boundary", owedCount, 2);
    refGrant = 1'b1;                // accepted at edge 2*NORM+1
    stepTo(2 * NORM + 1);
    refGrant = 1'b0;
    chk("R6 busy after accept", devBusy, 1);
    chk("R6 owed decremented", owedCount, 1);
    chk("R6 no request while busy", refReq, 0);
    stepTo(2 * NORM + 3);
    refGrant = 1'b1;                // ignored, device busy
    stepTo(2 * NORM + 4);
    refGrant = 1'b0;
    chk("R6 grant during busy ignored", owedCount, 1);
    stepTo(2 * NORM + TRFC_CYC);
    chk("R6 busy on last window cycle", devBusy, 1);
    chk("R8 row unchanged inside window", rowGroup, 0);
    stepTo(2 * NORM + 1 + TRFC_CYC);
    chk("R6 busy dropped", devBusy, 0);
    chk("R8 row advanced", rowGroup, 1);
    chk("R5 request back", refReq, 1);
  endtask

  task automatic t_stray_grant();
    doReset();
    refGrant = 1'b1;
    stepTo(20);
    refGrant = 1'b0;
    chk("R5 stray grant no busy", devBusy, 0);
    chk("R5 stray grant owed", owedCount, 0);
    chk("R5 stray grant row", rowGroup, 0);
  endtask

  task automatic t_hot_and_limit();
    doReset();
    hotTemp = 1'b1;
    stepTo(NORM - 1);
    chk("R4 first interval stays cool", owedCount, 0);
    stepTo(NORM);
    chk("R4 first boundary", owedCount, 1);
    stepTo(NORM + HOT - 1);
    chk("R3 before hot boundary", owedCount, 1);
    stepTo(NORM + HOT);
    chk("R3 hot boundary", owedCount, 2);
    hotTemp = 1'b0;                 // running interval keeps hot length
    stepTo(NORM + 2 * HOT - 1);
    chk("R4 running interval unchanged", owedCount, 2);
    chk("R7 not urgent below limit", refUrgent, 0);
    stepTo(NORM + 2 * HOT);
    chk("R4 hot interval completes", owedCount, 3);
    chk("R7 urgent at limit", refUrgent, 1);
    stepTo(2 * NORM + 2 * HOT - 1);
    chk("R4 cool interval after flag drop", owedCount, 3);
    stepTo(2 * NORM + 2 * HOT);
    chk("R7 saturated at limit", owedCount, POSTPONE_MAX);
    chk("R7 still urgent", refUrgent, 1);
    refGrant = 1'b1;                // drain: accepts every TRFC_CYC+1 cycles
    stepTo(2 * NORM + 2 * HOT + 3 * (TRFC_CYC + 1));
    refGrant = 1'b0;
    chk("R7 drained", owedCount, 0);
    chk("R7 urgent cleared", refUrgent, 0);
    chk("R8 three completions", rowGroup, 3);
    chk("R6 idle after drain", devBusy, 0);
  endtask

  task automatic t_window();
    int accepts;
    int overlap;
    doReset();
    refGrant = 1'b1;
    accepts = 0;
    overlap = 0;
    for (int i = 0; i < WINDOW; i++) begin
      stepTo(kNow + 1);
      if (refReq && refGrant) accepts++;
      if (refReq && devBusy) overlap++;
    end
    refGrant = 1'b0;
    chk("R9 grants in one window", accepts, REF_COUNT);
    chk("R9 no grant while busy", overlap, 0);
    stepTo(WINDOW + TRFC_CYC + 2);
    chk("R8 row wrapped after full cycle", rowGroup, 0);
  endtask

  initial begin
    t_reset();
    t_normal_and_grant();
    t_stray_grant();
    t_hot_and_limit();
    t_window();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule